// File: doc/BRIEF.md
# Core Boundary Isolation Wrapper

This block sits on the digital boundary of a core. Every signal that enters the core and every signal that leaves it passes through its own wrapper cell. A cell holds one flip-flop and a two-way select in front of that flip-flop. In normal operation the functional values flow straight through the wrapper with no added register stage. The cells also sample the functional values on every clock edge.

Two independent freeze controls come from the local test control register. The input-side freeze makes the core see the last captured boundary values instead of the live pins. This lets the core be tested on its own. The output-side freeze makes the neighbouring logic see the last captured core outputs. This isolates the neighbours from whatever the core does during its test.

The same cells form a dedicated serial chain, clocked by the test-rail clock. The chain runs from a serial input through the input cells in index order, then through the output cells in index order, to a serial output. Shifting the chain loads known stimulus into the boundary and unloads captured responses.

Top module: `io_iso_wrap`

## Requirements
- R1: An active-low asynchronous reset clears every cell to 0. Right after reset, with both freezes asserted, `core_in`, `pin_out` and `scan_out` all read 0.
- R2: When `shift_en`, `hold_in` and `hold_out` are all low, `core_in` equals `pin_in` and `pin_out` equals `core_out` in the same cycle, with no register stage.
- R3: On each clock edge where `shift_en` is low, every cell whose side is not frozen loads its functional value. Input cell i loads `pin_in[i]` and output cell j loads `core_out[j]`.
- R4: While `hold_in` is high and `shift_en` is low, the input cells keep their contents. `core_in` shows those contents and does not follow `pin_in`.
- R5: While `hold_out` is high and `shift_en` is low, the output cells keep their contents. `pin_out` shows those contents and does not follow `core_out`.
- R6: The two freezes act independently. `hold_in` alone leaves `pin_out` transparent to `core_out`, and `hold_out` alone leaves `core_in` transparent to `pin_in`.
- R7: On each clock edge with `shift_en` high, the chain shifts by one position:
  - input cell 0 takes `scan_in`;
  - each later cell takes the previous one, in the order input cells 0..N_IN-1, then output cells 0..N_OUT-1;
  - `scan_out` is the last output cell, so a bit entered at `scan_in` reaches `scan_out` after N_IN+N_OUT edges.
- R8: `shift_en` takes precedence over both freezes. The chain shifts even while `hold_in` or `hold_out` is high.
- R9: While `shift_en` is high, `core_in` and `pin_out` present the cell contents, not the live functional values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test-rail clock for all cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Serial shift enable |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (last output cell) |
| hold_in | input | 1 | Freeze for the input side |
| hold_out | input | 1 | Freeze for the output side |
| pin_in | input | N_IN | Functional values arriving from outside the core |
| core_in | output | N_IN | Values presented to the core |
| core_out | input | N_OUT | Functional values produced by the core |
| pin_out | output | N_OUT | Values presented to neighbouring logic |

## Verification
The bench changes `pin_in` and `core_out` while each freeze is high, alone and together. A cell that ignored its freeze would let the new values leak through, and a crossed control would freeze the wrong side.

The bench shifts distinct patterns with the freezes set. A wrong precedence would stall the chain, a misordered link would show bits at `scan_out` in a shuffled order, and an off-by-one would show them one edge early or late.

The bench also raises a freeze directly after transparent cycles. A design that captured on the wrong edge, or never captured in transparent mode, would present stale or reset values.

// File: rtl/io_iso_wrap.sv
module io_iso_wrap #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             hold_in,
  input  logic             hold_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out
);
  localparam int N_CELL = N_IN + N_OUT;

  logic [N_CELL-1:0] cell_q, cell_d, func_v, keep_v, link_v;

  assign func_v = {core_out, pin_in};
  assign keep_v = {{N_OUT{hold_out}}, {N_IN{hold_in}}};
  assign link_v = {cell_q[N_CELL-2:0], scan_in};

  always_comb begin
    if (shift_en) cell_d = link_v;
    else          cell_d = (keep_v & cell_q) | (~keep_v & func_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assign core_in  = (hold_in  | shift_en) ? cell_q[N_IN-1:0]      : pin_in;
  assign pin_out  = (hold_out | shift_en) ? cell_q[N_CELL-1:N_IN] : core_out;
  assign scan_out = cell_q[N_CELL-1];
endmodule

// File: rtl/io_iso_wrap_chk.sv
module io_iso_wrap_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             scan_in,
  input logic             scan_out,
  input logic             hold_in,
  input logic             hold_out,
  input logic [N_IN-1:0]  pin_in,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] pin_out
);
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_in && !shift_en && !$past(hold_in) && !$past(shift_en)) |-> core_in == $past(pin_in));

  p_freeze_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_in && !shift_en && $past(hold_in) && !$past(shift_en)) |-> $stable(core_in));

  p_freeze_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_out && !shift_en && $past(hold_out) && !$past(shift_en)) |-> ($stable(pin_out) && $stable(scan_out)));

  p_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_in && !hold_out && !shift_en) |-> pin_out == core_out);

  p_chain_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && $past(shift_en)) |-> core_in[0] == $past(scan_in));

  p_chain_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && $past(shift_en)) |-> pin_out[0] == $past(core_in[N_IN-1]));
endmodule

bind io_iso_wrap io_iso_wrap_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/tb_io_iso_wrap.sv
module tb_io_iso_wrap;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int NC = NI + NO;

  logic clk = 0, rst_n = 0;
  logic shift_en = 0, scan_in = 0, hold_in = 0, hold_out = 0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] pin_out;
  logic scan_out;

  int checks = 0, errors = 0;
  string phase = "";
  bit mdl[$];

  always #5 clk = ~clk;

  io_iso_wrap #(.N_IN(NI), .N_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .scan_in(scan_in),
    .scan_out(scan_out), .hold_in(hold_in), .hold_out(hold_out),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .pin_out(pin_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic compare();
    logic [NI-1:0] eci;
    logic [NO-1:0] epo;
    for (int i = 0; i < NI; i++) eci[i] = (hold_in || shift_en) ? mdl[i] : pin_in[i];
    for (int j = 0; j < NO; j++) epo[j] = (hold_out || shift_en) ? mdl[NI+j] : core_out[j];
    chk(shift_en ? "R9" : (hold_in ? "R4" : "R2"), 32'(core_in), 32'(eci));
    chk(shift_en ? "R9" : (hold_out ? "R5" : (hold_in ? "R6" : "R2")), 32'(pin_out), 32'(epo));
    chk(shift_en ? "R7" : "R3", 32'(scan_out), 32'(mdl[NC-1]));
  endtask

  task automatic step(logic [NI-1:0] pi, logic [NO-1:0] co, logic hi, logic ho, logic se, logic si);
    bit dropped;
    @(negedge clk);
    pin_in = pi; core_out = co; hold_in = hi; hold_out = ho; shift_en = se; scan_in = si;
    #1 compare();
    @(posedge clk);
    if (se) begin
      mdl.push_front(si);
      dropped = mdl.pop_back();
    end else begin
      for (int i = 0; i < NI; i++) if (!hi) mdl[i] = pi[i];
      for (int j = 0; j < NO; j++) if (!ho) mdl[NI+j] = co[j];
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) mdl.push_back(1'b0);
    hold_in = 1; hold_out = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset";
    #1;
    chk("R1", 32'(core_in), 0);
    chk("R1", 32'(pin_out), 0);
    chk("R1", 32'(scan_out), 0);
    step(4'hF, 3'h7, 1, 1, 0, 0);

    phase = "transparent";
    step(4'hA, 3'h5, 0, 0, 0, 0);
    step(4'h5, 3'h2, 0, 0, 0, 0);
    step(4'hC, 3'h6, 0, 0, 0, 0);

    phase = "input freeze R4 R6";
    for (int k = 0; k < 5; k++) step(4'(k * 3 + 1), 3'(k + 2), 1, 0, 0, 0);

    phase = "output freeze R5 R6";
    step(4'h9, 3'h3, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(4'(k * 5), 3'(~k), 0, 1, 0, 0);

    phase = "both frozen";
    step(4'h6, 3'h1, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(4'(15 - k), 3'(k), 1, 1, 0, 0);

    phase = "shift R7";
    for (int k = 0; k < NC + 4; k++) step(4'h3, 3'h4, 0, 0, 1, 1'((13'h1A5B >> k) & 1));

    phase = "shift under freeze R8";
    for (int k = 0; k < NC + 3; k++) step(4'h7, 3'h2, 1'(k & 1), 1'((k >> 1) & 1), 1, 1'((k * 7) % 3 == 0));
    step(4'h0, 3'h0, 1, 1, 0, 0);
    step(4'hF, 3'h7, 1, 1, 0, 0);

    phase = "mixed";
    for (int k = 0; k < 400; k++)
      step(4'($urandom), 3'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 3 == 0),
           1'($urandom % 4 == 0), 1'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule